// File: doc/BRIEF.md
# Recurring Sequence Replay Predictor

The block watches a stream of event identifiers, such as call-site addresses, each arriving with two measured durations: how long the event itself lasted and how long the idle gap after it lasted. While it is learning, it appends every entry to a history buffer. After each append it runs a search over that history for a span that occurs twice back to back, where neither copy overlaps the other and the later copy ends at the newest entry. The search tries the longest span first.

When such a span is found, the block locks onto it as the macro phase and switches to replay. In replay it shows the identifier it expects next, together with the durations seen at that point of the phase the last time round. Each incoming identifier is compared with this expectation. A hit moves the prediction on by one entry, wrapping at the end of the span. A miss drops the block back into learning, and learning starts again from a fresh history.

Power-management logic uses the prediction to schedule operating-point changes ahead of the next event.

Top module: `rsr_predictor`

## Requirements
- R1: After reset the block is learning: `pred_valid_o`=0, `phase_len_o`=0, `busy_o`=0 and `in_ready_o`=1.
- R2: While learning, each accepted entry starts a search. From the next cycle `busy_o`=1 and `in_ready_o`=0 until the search finishes.
- R3: A span of length L qualifies only if the newest L entries equal the L entries just before them. A repeat that overlaps itself, or that does not end at the newest entry, causes no lock.
- R4: The search tries L from floor(fill/2) down to 1 and locks the first L that qualifies, so the longest qualifying span wins. `phase_len_o` never exceeds DEPTH/2.
- R5: When a lock occurs, from the next cycle `pred_valid_o`=1, `phase_len_o`=L, and `pred_id_o` is the first identifier of the newest copy of the span.
- R6: In replay, an identifier equal to `pred_id_o` moves the prediction to the next entry of the span, wrapping to the first entry after the last one. `phase_len_o` is unchanged.
- R7: In replay, an identifier different from `pred_id_o` returns the block to learning (`pred_valid_o`=0, `phase_len_o`=0). The history restarts with that entry as its only element.
- R8: `pred_dur_o` and `pred_gap_o` give the durations of the predicted entry from its most recent occurrence. A hit overwrites the stored durations with the incoming ones.
- R9: In replay `in_ready_o`=1 and `busy_o`=0.
- R10: While learning, an entry that arrives with the history holding DEPTH entries restarts the history with that entry as its only element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input entry valid |
| in_ready_o | output | 1 | Block can accept an entry |
| in_id_i | input | ID_W | Event identifier |
| in_dur_i | input | DUR_W | Duration of the event |
| in_gap_i | input | DUR_W | Duration of the gap after the event |
| busy_o | output | 1 | Repeat search running |
| pred_valid_o | output | 1 | Replay mode, prediction valid |
| pred_id_o | output | ID_W | Predicted next identifier |
| pred_dur_o | output | DUR_W | Predicted event duration |
| pred_gap_o | output | DUR_W | Predicted gap duration |
| phase_len_o | output | $clog2(DEPTH+1) | Locked span length, 0 while learning |

## Verification
In replay, the prediction for a hit, and the drop to learning on a miss, both take effect one cycle after the accepting edge. While learning, `busy_o` rises one cycle after the accepting edge. A lock appears in the cycle after the last comparison of the search, and that is also the cycle in which `in_ready_o` returns high. The bench drives inputs on falling edges. After a learning-mode accept, it samples `busy_o` at the very next falling edge. It then polls `in_ready_o` on falling edges and checks every prediction output at the first falling edge where it reads high. A reference model recomputes the expected lock, index and durations after every entry.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic {
    MODE_REC = 1'b0,
    MODE_RPL = 1'b1
  } mode_e;
endpackage

// File: rtl/rsr_hist_buf.sv
module rsr_hist_buf #(
  parameter int DEPTH = 256,
  parameter int ID_W  = 32,
  parameter int DUR_W = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [DUR_W-1:0] wr_dur_i,
  input  logic [DUR_W-1:0] wr_gap_i,
  input  logic [AW-1:0]    a_idx_i,
  output logic [ID_W-1:0]  a_id_o,
  input  logic [AW-1:0]    b_idx_i,
  output logic [ID_W-1:0]  b_id_o,
  input  logic [AW-1:0]    c_idx_i,
  output logic [ID_W-1:0]  c_id_o,
  output logic [DUR_W-1:0] c_dur_o,
  output logic [DUR_W-1:0] c_gap_o
);
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [DUR_W-1:0] dur_q [DEPTH];
  logic [DUR_W-1:0] gap_q [DEPTH];

  // contents need no reset: only entries below the fill count are read
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      id_q[wr_idx_i]  <= wr_id_i;
      dur_q[wr_idx_i] <= wr_dur_i;
      gap_q[wr_idx_i] <= wr_gap_i;
    end
  end

  assign a_id_o  = id_q[a_idx_i];
  assign b_id_o  = id_q[b_idx_i];
  assign c_id_o  = id_q[c_idx_i];
  assign c_dur_o = dur_q[c_idx_i];
  assign c_gap_o = gap_q[c_idx_i];
endmodule

// File: rtl/rsr_search.sv
module rsr_search #(
  parameter int DEPTH = 256,
  parameter int ID_W  = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [FW-1:0]   fill_i,
  output logic [AW-1:0]   a_idx_o,
  output logic [AW-1:0]   b_idx_o,
  input  logic [ID_W-1:0] a_id_i,
  input  logic [ID_W-1:0] b_id_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            found_o,
  output logic [FW-1:0]   len_o
);
  logic          run_q;
  logic [FW-1:0] n_q, len_q, j_q;
  logic          match, last_j;

  // newest copy walks back from n-1, older copy sits len entries below it
  assign a_idx_o = AW'(n_q - FW'(1) - j_q);
  assign b_idx_o = AW'(n_q - FW'(1) - len_q - j_q);
  assign match   = (a_id_i == b_id_i);
  assign last_j  = (j_q == len_q - FW'(1));

  assign found_o = run_q && (len_q != '0) && match && last_j;
  assign done_o  = run_q && ((len_q == '0) || (match && last_j));
  assign busy_o  = run_q;
  assign len_o   = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      n_q   <= '0;
      len_q <= '0;
      j_q   <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      n_q   <= fill_i;
      len_q <= fill_i >> 1;
      j_q   <= '0;
    end else if (run_q) begin
      if (done_o) begin
        run_q <= 1'b0;
      end else if (match) begin
        j_q <= j_q + FW'(1);
      end else begin
        len_q <= len_q - FW'(1);
        j_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/rsr_predictor.sv
module rsr_predictor
  import rsr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int ID_W  = 32,
  parameter int DUR_W = 24,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ID_W-1:0]  in_id_i,
  input  logic [DUR_W-1:0] in_dur_i,
  input  logic [DUR_W-1:0] in_gap_i,
  output logic             busy_o,
  output logic             pred_valid_o,
  output logic [ID_W-1:0]  pred_id_o,
  output logic [DUR_W-1:0] pred_dur_o,
  output logic [DUR_W-1:0] pred_gap_o,
  output logic [FW-1:0]    phase_len_o
);
  mode_e          mode_q;
  logic [FW-1:0]  fill_q, plen_q, idx_q;
  logic [AW-1:0]  base_q;

  logic           acc, rec_acc, hit, miss, restart, start;
  logic [FW-1:0]  new_fill;
  logic [AW-1:0]  wr_idx, c_idx, a_idx, b_idx;
  logic [ID_W-1:0] a_id, b_id, c_id;
  logic           s_busy, s_done, s_found;
  logic [FW-1:0]  s_len;

  assign in_ready_o = (mode_q == MODE_RPL) || !s_busy;
  assign acc        = in_valid_i && in_ready_o;
  assign rec_acc    = acc && (mode_q == MODE_REC);
  assign hit        = acc && (mode_q == MODE_RPL) && (in_id_i == c_id);
  assign miss       = acc && (mode_q == MODE_RPL) && (in_id_i != c_id);
  assign restart    = miss || (rec_acc && (fill_q == FW'(DEPTH)));
  assign start      = rec_acc || miss;
  assign new_fill   = restart ? FW'(1) : fill_q + FW'(1);
  assign c_idx      = base_q + AW'(idx_q);
  // a hit rewrites the predicted slot to refresh its durations
  assign wr_idx     = hit ? c_idx : (restart ? '0 : AW'(fill_q));

  rsr_hist_buf #(.DEPTH(DEPTH), .ID_W(ID_W), .DUR_W(DUR_W)) u_buf (
    .clk_i    (clk_i),
    .wr_en_i  (acc),
    .wr_idx_i (wr_idx),
    .wr_id_i  (in_id_i),
    .wr_dur_i (in_dur_i),
    .wr_gap_i (in_gap_i),
    .a_idx_i  (a_idx),
    .a_id_o   (a_id),
    .b_idx_i  (b_idx),
    .b_id_o   (b_id),
    .c_idx_i  (c_idx),
    .c_id_o   (c_id),
    .c_dur_o  (pred_dur_o),
    .c_gap_o  (pred_gap_o)
  );

  rsr_search #(.DEPTH(DEPTH), .ID_W(ID_W)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .fill_i  (new_fill),
    .a_idx_o (a_idx),
    .b_idx_o (b_idx),
    .a_id_i  (a_id),
    .b_id_i  (b_id),
    .busy_o  (s_busy),
    .done_o  (s_done),
    .found_o (s_found),
    .len_o   (s_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_REC;
      fill_q <= '0;
      plen_q <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      if (start) fill_q <= new_fill;
      if (miss)  mode_q <= MODE_REC;
      if (hit)   idx_q  <= (idx_q == plen_q - FW'(1)) ? '0 : idx_q + FW'(1);
      if (s_done && s_found) begin
        mode_q <= MODE_RPL;
        plen_q <= s_len;
        base_q <= AW'(fill_q - s_len);
        idx_q  <= '0;
      end
    end
  end

  assign busy_o       = s_busy;
  assign pred_valid_o = (mode_q == MODE_RPL);
  assign pred_id_o    = c_id;
  assign phase_len_o  = pred_valid_o ? plen_q : '0;
endmodule

// File: rtl/rsr_predictor_chk.sv
module rsr_predictor_chk #(
  parameter int DEPTH = 256,
  parameter int ID_W  = 32,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [ID_W-1:0] in_id_i,
  input logic            busy_o,
  input logic            pred_valid_o,
  input logic [ID_W-1:0] pred_id_o,
  input logic [FW-1:0]   phase_len_o
);
  a_r2_accept_starts_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !pred_valid_o) |=> busy_o);

  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(phase_len_o) <= DEPTH / 2);

  a_r5_lock_after_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pred_valid_o) |-> (phase_len_o != '0) && $past(busy_o));

  a_r6_hit_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o && in_valid_i && in_id_i == pred_id_o) |=> pred_valid_o && $stable(phase_len_o));

  a_r7_miss_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o && in_valid_i && in_id_i != pred_id_o) |=> !pred_valid_o && busy_o);

  a_r9_replay_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> in_ready_o && !busy_o);
endmodule

bind rsr_predictor rsr_predictor_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .in_id_i      (in_id_i),
  .busy_o       (busy_o),
  .pred_valid_o (pred_valid_o),
  .pred_id_o    (pred_id_o),
  .phase_len_o  (phase_len_o)
);

// File: tb/rsr_predictor_tb.sv
`timescale 1ns/1ps
module rsr_predictor_tb;
  localparam int DEPTH = 16;
  localparam int ID_W  = 32;
  localparam int DUR_W = 24;
  localparam int FW    = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [ID_W-1:0]  in_id_i = '0;
  logic [DUR_W-1:0] in_dur_i = '0;
  logic [DUR_W-1:0] in_gap_i = '0;
  logic             busy_o, pred_valid_o;
  logic [ID_W-1:0]  pred_id_o;
  logic [DUR_W-1:0] pred_dur_o, pred_gap_o;
  logic [FW-1:0]    phase_len_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  rsr_predictor #(.DEPTH(DEPTH), .ID_W(ID_W), .DUR_W(DUR_W)) u_dut (.*);

  // reference model
  logic [ID_W-1:0]  m_id  [DEPTH];
  logic [DUR_W-1:0] m_dur [DEPTH];
  logic [DUR_W-1:0] m_gap [DEPTH];
  int m_fill = 0, m_base = 0, m_len = 0, m_idx = 0;
  bit m_rpl = 0;

  function automatic void model_search();
    for (int l = m_fill / 2; l >= 1; l--) begin
      bit ok = 1;
      for (int j = 0; j < l; j++)
        if (m_id[m_fill-1-j] != m_id[m_fill-1-l-j]) ok = 0;
      if (ok) begin
        m_rpl = 1; m_len = l; m_base = m_fill - l; m_idx = 0;
        return;
      end
    end
  endfunction

  function automatic void model_push(logic [ID_W-1:0] id, logic [DUR_W-1:0] d, logic [DUR_W-1:0] g);
    if (m_rpl) begin
      if (id == m_id[m_base+m_idx]) begin
        m_dur[m_base+m_idx] = d;
        m_gap[m_base+m_idx] = g;
        m_idx = (m_idx == m_len - 1) ? 0 : m_idx + 1;
      end else begin
        m_rpl = 0;
        m_id[0] = id; m_dur[0] = d; m_gap[0] = g; m_fill = 1;
      end
    end else begin
      if (m_fill == DEPTH) m_fill = 0;
      m_id[m_fill] = id; m_dur[m_fill] = d; m_gap[m_fill] = g;
      m_fill++;
      model_search();
    end
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " pred_valid"}, 64'(pred_valid_o), 64'(m_rpl));
    if (m_rpl) begin
      chk({tag, " pred_id"}, 64'(pred_id_o), 64'(m_id[m_base+m_idx]));
      chk({tag, " R8 pred_dur"}, 64'(pred_dur_o), 64'(m_dur[m_base+m_idx]));
      chk({tag, " R8 pred_gap"}, 64'(pred_gap_o), 64'(m_gap[m_base+m_idx]));
      chk({tag, " phase_len"}, 64'(phase_len_o), 64'(m_len));
      chk({tag, " R9 ready"}, 64'({in_ready_o, busy_o}), 64'(2'b10));
    end else begin
      chk({tag, " R7 phase_len zero"}, 64'(phase_len_o), 64'd0);
    end
  endtask

  task automatic send(logic [ID_W-1:0] id, logic [DUR_W-1:0] d, logic [DUR_W-1:0] g, string tag);
    bit was_rec;
    while (!in_ready_o) @(negedge clk_i);
    was_rec = !m_rpl;
    in_valid_i = 1'b1; in_id_i = id; in_dur_i = d; in_gap_i = g;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    model_push(id, d, g);
    if (was_rec) chk({tag, " R2 busy after accept"}, 64'({busy_o, in_ready_o}), 64'(2'b10));
    while (!in_ready_o) @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_fill = 0; m_rpl = 0; m_len = 0; m_idx = 0; m_base = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset();
    // R1 reset state
    chk("R1 ready", 64'(in_ready_o), 64'd1);
    chk("R1 pred_valid", 64'(pred_valid_o), 64'd0);
    chk("R1 phase_len", 64'(phase_len_o), 64'd0);
    chk("R1 busy", 64'(busy_o), 64'd0);

    // R3: A B C A B does not lock; C completes a length-3 repeat (R5)
    send(32'hA, 24'd10, 24'd11, "R3");
    send(32'hB, 24'd20, 24'd21, "R3");
    send(32'hC, 24'd30, 24'd31, "R3");
    send(32'hA, 24'd12, 24'd13, "R3");
    send(32'hB, 24'd22, 24'd23, "R3");
    chk("R3 no lock on offset repeat", 64'(pred_valid_o), 64'd0);
    send(32'hC, 24'd32, 24'd33, "R5");
    chk("R5 lock len", 64'(phase_len_o), 64'd3);
    chk("R5 first id", 64'(pred_id_o), 64'hA);
    chk("R8 dur from last occurrence", 64'(pred_dur_o), 64'd12);

    // R6 advance and wrap, R8 refresh on hit
    send(32'hA, 24'd100, 24'd101, "R6");
    chk("R6 next id", 64'(pred_id_o), 64'hB);
    send(32'hB, 24'd200, 24'd201, "R6");
    send(32'hC, 24'd300, 24'd301, "R6");
    chk("R6 wrap id", 64'(pred_id_o), 64'hA);
    chk("R8 refreshed dur", 64'(pred_dur_o), 64'd100);
    chk("R8 refreshed gap", 64'(pred_gap_o), 64'd101);

    // R7 mismatch restarts history
    send(32'hF0, 24'd5, 24'd6, "R7");
    chk("R7 dropped", 64'(pred_valid_o), 64'd0);
    send(32'hA, 24'd1, 24'd1, "R7");
    chk("R7 no lock from old history", 64'(pred_valid_o), 64'd0);
    send(32'hB, 24'd1, 24'd1, "R7");
    send(32'hA, 24'd2, 24'd2, "R7");
    send(32'hB, 24'd2, 24'd2, "R7");
    chk("R7 relock len", 64'(phase_len_o), 64'd2);

    // R4 longer span: length 5
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 5; k++) send(32'h50 + k, 24'(k + r), 24'(k), "R4");
    chk("R4 len 5", 64'(phase_len_o), 64'd5);
    chk("R4 first id", 64'(pred_id_o), 64'h50);

    // R10 full history restarts
    do_reset();
    for (int k = 0; k < DEPTH; k++) send(32'h100 + k, 24'(k), 24'(k), "R10");
    send(32'h100 + DEPTH - 1, 24'd9, 24'd9, "R10");
    chk("R10 restart no lock", 64'(pred_valid_o), 64'd0);
    send(32'h100 + DEPTH - 1, 24'd8, 24'd8, "R10");
    chk("R10 lock len 1", 64'(phase_len_o), 64'd1);

    // random patterns over a small alphabet
    do_reset();
    for (int it = 0; it < 60; it++) begin
      int plen = 1 + int'($urandom % 4);
      int reps = 2 + int'($urandom % 3);
      logic [ID_W-1:0] pat [4];
      for (int k = 0; k < 4; k++) pat[k] = 1 + ($urandom % 4);
      for (int r = 0; r < reps; r++)
        for (int k = 0; k < plen; k++)
          send(pat[k], 24'($urandom % 1000), 24'($urandom % 1000), "RND R5 R6 R7 R8");
      if ($urandom % 3 == 0) send(1 + ($urandom % 4), 24'd1, 24'd2, "RND R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule